// File: doc/BRIEF.md
# Double-Rate Stub Frame Link

This block holds both ends of a point-to-point link for track-segment stubs. Each stub is a 32-bit record of typed fields, one per bunch crossing. The link carries it as two 16-bit half-words at twice the crossing rate. The fast clock runs the whole block. A slot enable input marks the fast-rate slots.

The transmit end takes a stub on the crossing strobe. In the next two slots it sends the first half-word and then the second. It raises a first-frame marker with the first half-word. When there is no stub, or no strobe arrives, it sends all-zero half-words, so the far end sees the valid flag clear.

The receive end is given the marker as its phase input. It pairs the marked half-word with the half-word in the slot that follows. It then rebuilds every field and pulses a stub strobe for one clock. The valid and sync-error flags are reported as ordinary fields of the rebuilt stub.

Top module: `stub_frame_link`

## Requirements
- R1: The first half-word has this layout: valid flag at bit 15, quality at bits 14:11, chamber id at bits 10:7, wire group at bits 6:0.
- R2: The second half-word has this layout: pattern number at bits 15:12, crossing-number bit 0 at bit 11, sync-error flag at bit 10, crossing-number bit 1 at bit 9, bend sign at bit 8, half-strip number at bits 7:0.
- R3: When strobe and slot enable are sampled high at a clock edge, the first half-word appears on the frame output after that edge, with the first-frame marker at 1. The second half-word appears after the next enabled edge, with the marker at 0.
- R4: An all-zero half-word is sent in both slots when a strobe arrives with the stub-present input low. An all-zero half-word is also sent in any enabled slot after the second half-word when no strobe arrives.
- R5: When a half-word arrives with the phase input at 1, and the next enabled slot brings a half-word with the phase input at 0, the rebuilt fields (R1, R2 layout) and the stub strobe appear after that second edge.
- R6: The stub strobe is high for exactly one clock per rebuilt stub.
- R7: A half-word with the phase input at 0 that does not follow a marked half-word produces no stub strobe and leaves the rebuilt fields unchanged.
- R8: While slot enable is low, the frame output, the marker and the receive pairing state hold.
- R9: After reset the frame output, marker, stub strobe and all rebuilt fields are 0.
- R10: With the frame output and marker looped to the receive inputs, every stub comes back bit-exact and in order, including stubs with the sync-error flag set and stubs with the valid flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (twice crossing rate) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotEn | input | 1 | Slot enable for the double-rate slots |
| bxStrobe | input | 1 | Crossing strobe, sampled with slotEn |
| txHave | input | 1 | A stub is present on the transmit fields |
| txHalfStrip | input | 8 | Half-strip number |
| txPattern | input | 4 | Pattern number |
| txBend | input | 1 | Left/right bend sign |
| txQuality | input | 4 | Quality |
| txWireGroup | input | 7 | Wire group |
| txChamber | input | 4 | Chamber id |
| txBxn | input | 2 | Crossing-number low bits |
| txValid | input | 1 | Valid-pattern flag |
| txSyncErr | input | 1 | Upstream sync-error flag |
| txFrame | output | 16 | Transmitted half-word |
| txFirst | output | 1 | Marks the first half-word |
| rxFrame | input | 16 | Received half-word |
| rxFirst | input | 1 | Phase input marking the first half-word |
| rxHalfStrip | output | 8 | Rebuilt half-strip number |
| rxPattern | output | 4 | Rebuilt pattern number |
| rxBend | output | 1 | Rebuilt bend sign |
| rxQuality | output | 4 | Rebuilt quality |
| rxWireGroup | output | 7 | Rebuilt wire group |
| rxChamber | output | 4 | Rebuilt chamber id |
| rxBxn | output | 2 | Rebuilt crossing-number bits |
| rxValid | output | 1 | Rebuilt valid-pattern flag |
| rxSyncErr | output | 1 | Rebuilt sync-error flag |
| rxStubStrobe | output | 1 | One-clock pulse when a stub is rebuilt |

## Verification
A wrong transmit phase state shows on the frame output in the first slot after a strobe: the second half-word comes out where the first belongs, or the marker is wrong. A swapped or misplaced field is seen at once in the frame value. In the loopback it also shows two slots later as a wrong rebuilt field. A stuck receive pairing flag shows in the slot after an unmarked half-word, either as a spurious stub strobe or as a missing strobe after a proper pair. A bad hold under a low slot enable corrupts the frame output in the very next clock.

// File: rtl/stubLinkPkg.sv
package stubLinkPkg;

  localparam int FRAME_W   = 16;
  localparam int STUB_W    = 2 * FRAME_W;
  localparam int HS_W      = 8;
  localparam int PAT_W     = 4;
  localparam int QUAL_W    = 4;
  localparam int WG_W      = 7;
  localparam int CH_W      = 4;
  localparam int BX_W      = 2;

  typedef struct packed {
    logic              valid;
    logic [QUAL_W-1:0] quality;
    logic [CH_W-1:0]   chamber;
    logic [WG_W-1:0]   wireGroup;
    logic [PAT_W-1:0]  pattern;
    logic [BX_W-1:0]   bxn;
    logic              syncErr;
    logic              bend;
    logic [HS_W-1:0]   halfStrip;
  } stubT;

  typedef struct packed {
    logic txLoad;
    logic txAdvance;
    logic txBlank;
    logic rxCapture;
    logic rxEmit;
  } linkCtrlT;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } txPhaseT;

  function automatic logic [FRAME_W-1:0] packFirst(input stubT s);
    return {s.valid, s.quality, s.chamber, s.wireGroup};
  endfunction

  // crossing-number bits straddle the sync-error flag
  function automatic logic [FRAME_W-1:0] packSecond(input stubT s);
    return {s.pattern, s.bxn[0], s.syncErr, s.bxn[1], s.bend, s.halfStrip};
  endfunction

  function automatic stubT unpackPair(input logic [FRAME_W-1:0] f1,
                                      input logic [FRAME_W-1:0] f2);
    stubT s;
    s.valid     = f1[15];
    s.quality   = f1[14:11];
    s.chamber   = f1[10:7];
    s.wireGroup = f1[6:0];
    s.pattern   = f2[15:12];
    s.bxn       = {f2[9], f2[11]};
    s.syncErr   = f2[10];
    s.bend      = f2[8];
    s.halfStrip = f2[7:0];
    return s;
  endfunction

endpackage

// File: rtl/stubLinkCtrl.sv
module stubLinkCtrl
  import stubLinkPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     slotEn,
  input  logic     bxStrobe,
  input  logic     rxFirst,
  output logic     txFirst,
  output linkCtrlT ctrl
);

  txPhaseT phaseQ;
  txPhaseT phaseD;
  logic    rxArmedQ;
  logic    rxArmedD;

  always_comb begin
    phaseD = phaseQ;
    if (slotEn) begin
      if (bxStrobe)               phaseD = PH_FIRST;
      else if (phaseQ == PH_FIRST) phaseD = PH_SECOND;
      else                         phaseD = PH_IDLE;
    end
  end

  always_comb begin
    rxArmedD = rxArmedQ;
    if (slotEn) rxArmedD = rxFirst;
  end

  always_comb begin
    ctrl           = '0;
    ctrl.txLoad    = slotEn && bxStrobe;
    ctrl.txAdvance = slotEn && !bxStrobe && (phaseQ == PH_FIRST);
    ctrl.txBlank   = slotEn && !bxStrobe && (phaseQ != PH_FIRST);
    ctrl.rxCapture = slotEn && rxFirst;
    ctrl.rxEmit    = slotEn && !rxFirst && rxArmedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      rxArmedQ <= 1'b0;
    end else begin
      phaseQ   <= phaseD;
      rxArmedQ <= rxArmedD;
    end
  end

  assign txFirst = (phaseQ == PH_FIRST);

  // R3: marker drops after the first slot when no new strobe arrives
  a_r3_first_then_second: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && !bxStrobe && txFirst |=> !txFirst);

  // R3: an enabled strobe raises the marker
  a_r3_marker_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && bxStrobe |=> txFirst);

  // R7: an unmarked enabled slot leaves nothing to pair with
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && !rxFirst |=> !ctrl.rxEmit);

  // R8: pairing state holds when the slot is not enabled
  a_r8_arm_hold: assert property (@(posedge clk) disable iff (!rstN)
    !slotEn |=> $stable(rxArmedQ) && $stable(phaseQ));

endmodule

// File: rtl/stubLinkDatapath.sv
module stubLinkDatapath
  import stubLinkPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  linkCtrlT           ctrl,
  input  logic               txHave,
  input  stubT               txStub,
  input  logic [FRAME_W-1:0] rxFrame,
  output logic [FRAME_W-1:0] txFrame,
  output stubT               rxStub,
  output logic               rxStubStrobe
);

  logic [FRAME_W-1:0] txFrameQ;
  logic [FRAME_W-1:0] pendQ;
  logic [FRAME_W-1:0] holdQ;
  stubT               stubQ;
  logic               strobeQ;
  logic [FRAME_W-1:0] loadFirst;
  logic [FRAME_W-1:0] loadSecond;

  always_comb begin
    loadFirst  = txHave ? packFirst(txStub)  : '0;
    loadSecond = txHave ? packSecond(txStub) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFrameQ <= '0;
      pendQ    <= '0;
    end else if (ctrl.txLoad) begin
      txFrameQ <= loadFirst;
      pendQ    <= loadSecond;
    end else if (ctrl.txAdvance) begin
      txFrameQ <= pendQ;
      pendQ    <= '0;
    end else if (ctrl.txBlank) begin
      txFrameQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= '0;
      stubQ   <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= ctrl.rxEmit;
      if (ctrl.rxCapture) holdQ <= rxFrame;
      if (ctrl.rxEmit)    stubQ <= unpackPair(holdQ, rxFrame);
    end
  end

  assign txFrame      = txFrameQ;
  assign rxStub       = stubQ;
  assign rxStubStrobe = strobeQ;

  // R6: rebuilt-stub strobe is a single-clock pulse
  a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ |=> !strobeQ);

  // R8: with no transmit strobe from control the frame holds
  a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.txLoad || ctrl.txAdvance || ctrl.txBlank) |=> $stable(txFrameQ));

  // R7: rebuilt fields change only together with the strobe
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rxEmit |=> $stable(stubQ));

endmodule

// File: rtl/stub_frame_link.sv
module stub_frame_link
  import stubLinkPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotEn,
  input  logic               bxStrobe,
  input  logic               txHave,
  input  logic [HS_W-1:0]    txHalfStrip,
  input  logic [PAT_W-1:0]   txPattern,
  input  logic               txBend,
  input  logic [QUAL_W-1:0]  txQuality,
  input  logic [WG_W-1:0]    txWireGroup,
  input  logic [CH_W-1:0]    txChamber,
  input  logic [BX_W-1:0]    txBxn,
  input  logic               txValid,
  input  logic               txSyncErr,
  output logic [FRAME_W-1:0] txFrame,
  output logic               txFirst,
  input  logic [FRAME_W-1:0] rxFrame,
  input  logic               rxFirst,
  output logic [HS_W-1:0]    rxHalfStrip,
  output logic [PAT_W-1:0]   rxPattern,
  output logic               rxBend,
  output logic [QUAL_W-1:0]  rxQuality,
  output logic [WG_W-1:0]    rxWireGroup,
  output logic [CH_W-1:0]    rxChamber,
  output logic [BX_W-1:0]    rxBxn,
  output logic               rxValid,
  output logic               rxSyncErr,
  output logic               rxStubStrobe
);

  linkCtrlT ctrl;
  stubT     txStub;
  stubT     rxStub;

  always_comb begin
    txStub.valid     = txValid;
    txStub.quality   = txQuality;
    txStub.chamber   = txChamber;
    txStub.wireGroup = txWireGroup;
    txStub.pattern   = txPattern;
    txStub.bxn       = txBxn;
    txStub.syncErr   = txSyncErr;
    txStub.bend      = txBend;
    txStub.halfStrip = txHalfStrip;
  end

  stubLinkCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotEn   (slotEn),
    .bxStrobe (bxStrobe),
    .rxFirst  (rxFirst),
    .txFirst  (txFirst),
    .ctrl     (ctrl)
  );

  stubLinkDatapath uData (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .txHave       (txHave),
    .txStub       (txStub),
    .rxFrame      (rxFrame),
    .txFrame      (txFrame),
    .rxStub       (rxStub),
    .rxStubStrobe (rxStubStrobe)
  );

  assign rxHalfStrip = rxStub.halfStrip;
  assign rxPattern   = rxStub.pattern;
  assign rxBend      = rxStub.bend;
  assign rxQuality   = rxStub.quality;
  assign rxWireGroup = rxStub.wireGroup;
  assign rxChamber   = rxStub.chamber;
  assign rxBxn       = rxStub.bxn;
  assign rxValid     = rxStub.valid;
  assign rxSyncErr   = rxStub.syncErr;

  // R4: a strobe without a stub sends a zero first half-word
  a_r4_blank_no_stub: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && bxStrobe && !txHave |=> txFrame == '0);

  // R1: valid flag lands in the top bit of the first half-word
  a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && bxStrobe && txHave |=> txFrame[FRAME_W-1] == $past(txValid));

  // R2: half-strip lands in the low byte of the second half-word
  a_r2_half_strip: assert property (@(posedge clk) disable iff (!rstN)
    slotEn && bxStrobe && txHave ##1 slotEn && !bxStrobe
      |=> txFrame[HS_W-1:0] == $past(txHalfStrip, 2));

endmodule

// File: tb/stub_frame_link_test.sv
module stub_frame_link_test;

  typedef struct packed {
    logic       valid;
    logic [3:0] quality;
    logic [3:0] chamber;
    logic [6:0] wireGroup;
    logic [3:0] pattern;
    logic [1:0] bxn;
    logic       syncErr;
    logic       bend;
    logic [7:0] halfStrip;
  } tbStubT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotEn = 1'b0;
  logic        bxStrobe = 1'b0;
  logic        txHave = 1'b0;
  tbStubT      drv = '0;
  logic [15:0] txFrame;
  logic        txFirst;
  logic        loopBack = 1'b1;
  logic [15:0] rxFrameDrv = '0;
  logic        rxFirstDrv = 1'b0;
  logic [15:0] rxFrame;
  logic        rxFirst;
  logic [7:0]  rxHalfStrip;
  logic [3:0]  rxPattern;
  logic        rxBend;
  logic [3:0]  rxQuality;
  logic [6:0]  rxWireGroup;
  logic [3:0]  rxChamber;
  logic [1:0]  rxBxn;
  logic        rxValid;
  logic        rxSyncErr;
  logic        rxStubStrobe;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;
  bit monEn = 0;
  tbStubT expQ[$];
  int rxCount = 0;

  always #5 clk = ~clk;

  assign rxFrame = loopBack ? txFrame : rxFrameDrv;
  assign rxFirst = loopBack ? txFirst : rxFirstDrv;

  stub_frame_link uut (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .bxStrobe(bxStrobe), .txHave(txHave),
    .txHalfStrip(drv.halfStrip), .txPattern(drv.pattern), .txBend(drv.bend),
    .txQuality(drv.quality), .txWireGroup(drv.wireGroup), .txChamber(drv.chamber),
    .txBxn(drv.bxn), .txValid(drv.valid), .txSyncErr(drv.syncErr),
    .txFrame(txFrame), .txFirst(txFirst), .rxFrame(rxFrame), .rxFirst(rxFirst),
    .rxHalfStrip(rxHalfStrip), .rxPattern(rxPattern), .rxBend(rxBend),
    .rxQuality(rxQuality), .rxWireGroup(rxWireGroup), .rxChamber(rxChamber),
    .rxBxn(rxBxn), .rxValid(rxValid), .rxSyncErr(rxSyncErr),
    .rxStubStrobe(rxStubStrobe)
  );

  function automatic logic [15:0] expFirst(input tbStubT s);
    return {s.valid, s.quality, s.chamber, s.wireGroup};
  endfunction

  function automatic logic [15:0] expSecond(input tbStubT s);
    logic [15:0] f;
    f[15:12] = s.pattern;
    f[11]    = s.bxn[0];
    f[10]    = s.syncErr;
    f[9]     = s.bxn[1];
    f[8]     = s.bend;
    f[7:0]   = s.halfStrip;
    return f;
  endfunction

  function automatic tbStubT rxSeen();
    tbStubT s;
    s.valid = rxValid; s.quality = rxQuality; s.chamber = rxChamber;
    s.wireGroup = rxWireGroup; s.pattern = rxPattern; s.bxn = rxBxn;
    s.syncErr = rxSyncErr; s.bend = rxBend; s.halfStrip = rxHalfStrip;
    return s;
  endfunction

  function automatic tbStubT randStub();
    tbStubT s;
    s = tbStubT'($urandom);
    if (($urandom % 4) == 0) s.syncErr = 1'b1;
    if (($urandom % 5) == 0) s.valid = 1'b0;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R10 loopback monitor
  always @(negedge clk) begin
    if (monEn && rxStubStrobe) begin
      tbStubT e;
      rxCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected stub", rxSeen(), 32'h0);
      end else begin
        e = expQ.pop_front();
        check(rxSeen() == e, "R10 round trip", rxSeen(), e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    tbStubT a;
    tbStubT b;
    tbStubT held;
    logic [15:0] x;
    logic [15:0] y;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    // R9 reset state
    check(txFrame == 16'h0 && !txFirst, "R9 tx reset", {txFirst, txFrame}, 0);
    check(!rxStubStrobe && rxSeen() == '0, "R9 rx reset", rxSeen(), 0);
    rstN = 1'b1;
    slotEn = 1'b1;
    @(negedge clk);

    // directed stub with distinct field values
    a = '{valid:1'b1, quality:4'hA, chamber:4'h5, wireGroup:7'h53, pattern:4'hC,
          bxn:2'b01, syncErr:1'b1, bend:1'b0, halfStrip:8'hB7};
    bxStrobe = 1'b1; txHave = 1'b1; drv = a;
    @(negedge clk);
    bxStrobe = 1'b0; txHave = 1'b0; drv = '0;
    check(txFrame == expFirst(a), "R1 first layout", txFrame, expFirst(a));
    check(txFirst == 1'b1, "R3 marker on first", txFirst, 1);
    @(negedge clk);
    check(txFrame == expSecond(a), "R2 second layout", txFrame, expSecond(a));
    check(txFirst == 1'b0, "R3 marker off on second", txFirst, 0);
    check(!rxStubStrobe, "R5 no strobe yet", rxStubStrobe, 0);
    @(negedge clk);
    check(rxStubStrobe == 1'b1, "R5 strobe after pair", rxStubStrobe, 1);
    check(rxSeen() == a, "R5 rebuilt fields", rxSeen(), a);
    check(txFrame == 16'h0, "R4 idle slot zero", txFrame, 0);
    @(negedge clk);
    check(!rxStubStrobe, "R6 single pulse", rxStubStrobe, 0);

    // bxn order: only bit 1 set
    b = '{valid:1'b1, quality:4'h3, chamber:4'hE, wireGroup:7'h0C, pattern:4'h1,
          bxn:2'b10, syncErr:1'b0, bend:1'b1, halfStrip:8'h2D};
    bxStrobe = 1'b1; txHave = 1'b1; drv = b;
    @(negedge clk);
    bxStrobe = 1'b0; txHave = 1'b0; drv = '0;
    @(negedge clk);
    check(txFrame == expSecond(b), "R2 bxn bit split", txFrame, expSecond(b));
    @(negedge clk);
    check(rxSeen() == b && rxStubStrobe, "R5 bxn rebuilt", rxSeen(), b);

    // no stub present: zero frames, valid clear
    bxStrobe = 1'b1; txHave = 1'b0; drv = a;
    @(negedge clk);
    bxStrobe = 1'b0; drv = '0;
    check(txFrame == 16'h0 && txFirst, "R4 blank first", {txFirst, txFrame}, 32'h10000);
    @(negedge clk);
    check(txFrame == 16'h0, "R4 blank second", txFrame, 0);
    @(negedge clk);
    check(rxStubStrobe && rxSeen() == '0, "R4 rx valid clear", rxSeen(), 0);

    // slot enable low holds everything
    bxStrobe = 1'b1; txHave = 1'b1; drv = b;
    @(negedge clk);
    bxStrobe = 1'b0; txHave = 1'b0; drv = '0; slotEn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(txFrame == expFirst(b) && txFirst, "R8 hold first", txFrame, expFirst(b));
    end
    slotEn = 1'b1;
    @(negedge clk);
    slotEn = 1'b0;
    check(txFrame == expSecond(b), "R8 resume second", txFrame, expSecond(b));
    @(negedge clk);
    check(!rxStubStrobe, "R8 pairing waits", rxStubStrobe, 0);
    slotEn = 1'b1;
    @(negedge clk);
    check(rxStubStrobe && rxSeen() == b, "R8 pair after gap", rxSeen(), b);

    // unpaired frames are ignored
    @(negedge clk);
    held = rxSeen();
    loopBack = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rxFirstDrv = 1'b0;
      rxFrameDrv = 16'($urandom);
      @(negedge clk);
      check(!rxStubStrobe && rxSeen() == held, "R7 unpaired ignored", rxSeen(), held);
    end
    x = 16'($urandom);
    y = 16'($urandom);
    rxFirstDrv = 1'b1; rxFrameDrv = x;
    @(negedge clk);
    rxFirstDrv = 1'b0; rxFrameDrv = y;
    @(negedge clk);
    rxFrameDrv = 16'($urandom);
    begin
      tbStubT e;
      e = {x, y[15:12], y[9], y[11], y[10], y[8], y[7:0]};
      check(rxStubStrobe && rxSeen() == e, "R5 direct pair", rxSeen(), e);
    end
    @(negedge clk);
    check(!rxStubStrobe, "R7 frame after pair ignored", rxStubStrobe, 0);
    loopBack = 1'b1;
    rxFirstDrv = 1'b0;
    repeat (2) @(negedge clk);

    // random back-to-back loopback at full slot rate
    monEn = 1;
    for (int i = 0; i < 300; i++) begin
      a = randStub();
      expQ.push_back(a);
      bxStrobe = 1'b1; txHave = 1'b1; drv = a;
      @(negedge clk);
      bxStrobe = 1'b0; txHave = 1'b0; drv = '0;
      @(negedge clk);
    end
    // random loopback with slot enable every other clock
    for (int i = 0; i < 200; i++) begin
      a = randStub();
      expQ.push_back(a);
      slotEn = 1'b1; bxStrobe = 1'b1; txHave = 1'b1; drv = a;
      @(negedge clk);
      slotEn = 1'b0; bxStrobe = 1'b0; txHave = 1'b0; drv = '0;
      @(negedge clk);
      slotEn = 1'b1;
      @(negedge clk);
      slotEn = 1'b0;
      @(negedge clk);
    end
    slotEn = 1'b1;
    repeat (6) @(negedge clk);
    check(expQ.size() == 0 && rxCount == 500, "R10 all stubs returned", rxCount, 500);
    finishRun();
  end

endmodule